// File: doc/BRIEF.md
# Charge-Redistribution SAR Conversion Controller

This block is the digital sequencer for an N-bit successive-approximation converter built on a binary-weighted capacitor array. A one-cycle start request launches a conversion. The controller first takes the array through three preparation phases, in a fixed order. In the first, every capacitor is tied to the ground/offset node, which removes the comparator offset. In the second, every capacitor is tied to the analog input to sample it. In the third, the array is reconnected so that the sampled charge drives the comparator.

After the preparation phases, the controller resolves one bit per clock, starting at the most significant bit. For each trial it drives the capacitor under test to the reference. It keeps that bit when the comparator reports high. When the comparator reports low, it clears the bit and returns that capacitor to ground. The switch selects for each capacitor and the three phase switches are outputs, so the analog array can be driven directly. The N-bit code appears on a result register, and a done pulse marks it as new.

The length of each preparation phase is a parameter. A conversion therefore takes the sum of the three phase lengths plus N clocks.

Top module: `sar_ctrl`

## Requirements
- R1: While idle, and after a synchronous active-low reset, every capacitor select is open (code 00), all three phase switches are low, and busy, done and result are 0. Capacitor i uses cap_sel bits [2i+1:2i].
- R2: A start seen at a clock edge while idle raises busy from the next cycle. The discharge phase then lasts T_DIS cycles, with sw_dis high and every capacitor on ground/offset (code 01).
- R3: The sample phase follows discharge and lasts T_SMP cycles, with sw_smp high and every capacitor on the input (code 10).
- R4: The hold phase follows sampling and lasts T_HLD cycles, with sw_hld high and every capacitor on ground. sw_hld stays high through all bit trials. At most one phase switch is high at any time.
- R5: Bit trials take one clock each, from bit N-1 down to bit 0. During the trial of bit k, capacitor k is on the reference (code 11). Each higher capacitor is on the reference if its bit was kept and on ground otherwise. Every lower capacitor is on ground.
- R6: The comparator level at the clock edge that ends a trial sets that bit: high keeps it as 1, low makes it 0.
- R7: done is high for exactly one cycle, directly after the LSB trial. In that same cycle busy is low and result holds the new code. result does not change at any other time except reset. busy is high for T_DIS+T_SMP+T_HLD+N cycles.
- R8: A start pulse while busy has no effect. The conversion timing does not change, and no second conversion follows.
- R9: Pulling rst_n low mid-conversion returns the controller to idle at the next edge, and it stays idle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request |
| cmp_hi | input | 1 | Comparator decision |
| cap_sel | output | 2*N | Per-capacitor switch select |
| sw_dis | output | 1 | Discharge / offset-cancel switch |
| sw_smp | output | 1 | Sample switch |
| sw_hld | output | 1 | Hold / redistribute switch |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | N | Converted code |

## Verification
The bench converts random and directed codes through an ideal comparator that compares the input code against the reference-weighted sum of the capacitor selects. A controller that tested bits in the wrong order, or failed to drop a rejected capacitor back to ground, would produce wrong codes at 0, full scale, mid-scale and alternating patterns. Non-unit phase lengths catch any phase that runs one cycle too long or too short. The bench also forces the comparator constantly high and constantly low, injects a start pulse during a conversion, and resets mid-conversion. These cases expose a controller that restarts, extends the conversion, or keeps stale state after reset.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_DIS  = 3'd1,
      PH_SMP  = 3'd2,
      PH_HLD  = 3'd3,
      PH_TRY  = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      SEL_OPEN = 2'b00,
      SEL_GND  = 2'b01,
      SEL_IN   = 2'b10,
      SEL_REF  = 2'b11
   } capsel_e;
endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
   import sar_pkg::*;
#(
   parameter int N     = 8,
   parameter int T_DIS = 1,
   parameter int T_SMP = 1,
   parameter int T_HLD = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_e ph,
   output logic   ph_last
);
   localparam int M1   = (T_DIS > T_SMP) ? T_DIS : T_SMP;
   localparam int M2   = (M1 > T_HLD) ? M1 : T_HLD;
   localparam int MAXD = (M2 > N) ? M2 : N;
   localparam int CW   = $clog2(MAXD + 1);

   logic [CW-1:0] cnt;

   assign ph_last = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph  <= PH_DIS;
               cnt <= CW'(T_DIS - 1);
            end
            PH_DIS: if (ph_last) begin
               ph  <= PH_SMP;
               cnt <= CW'(T_SMP - 1);
            end else cnt <= cnt - 1'b1;
            PH_SMP: if (ph_last) begin
               ph  <= PH_HLD;
               cnt <= CW'(T_HLD - 1);
            end else cnt <= cnt - 1'b1;
            PH_HLD: if (ph_last) begin
               ph  <= PH_TRY;
               cnt <= CW'(N - 1);
            end else cnt <= cnt - 1'b1;
            PH_TRY: if (ph_last) ph <= PH_IDLE;
                    else cnt <= cnt - 1'b1;
            default: ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
   import sar_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  phase_e       ph,
   input  logic         ph_last,
   input  logic         cmp_hi,
   output logic [N-1:0] trial_bits,
   output logic [N-1:0] result,
   output logic         done
);
   localparam logic [N-1:0] MSB_ONE = {1'b1, {(N-1){1'b0}}};

   logic [N-1:0] kept;
   logic [N-1:0] ptr;
   logic [N-1:0] kept_nxt;

   assign trial_bits = kept | ptr;
   assign kept_nxt   = cmp_hi ? (kept | ptr) : kept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kept   <= '0;
         ptr    <= '0;
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (ph == PH_HLD && ph_last) begin
            kept <= '0;
            ptr  <= MSB_ONE;
         end else if (ph == PH_TRY) begin
            kept <= kept_nxt;
            ptr  <= ptr >> 1;
            if (ph_last) begin
               result <= kept_nxt;
               done   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sar_switch_map.sv
module sar_switch_map
   import sar_pkg::*;
#(
   parameter int N = 8
) (
   input  phase_e         ph,
   input  logic [N-1:0]   trial_bits,
   output logic [2*N-1:0] cap_sel
);
   for (genvar i = 0; i < N; i++) begin : g_cap
      capsel_e sel;
      always_comb begin
         case (ph)
            PH_DIS:  sel = SEL_GND;
            PH_SMP:  sel = SEL_IN;
            PH_HLD:  sel = SEL_GND;
            PH_TRY:  sel = trial_bits[i] ? SEL_REF : SEL_GND;
            default: sel = SEL_OPEN;
         endcase
      end
      assign cap_sel[2*i +: 2] = sel;
   end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
   import sar_pkg::*;
#(
   parameter int N     = 8,
   parameter int T_DIS = 1,
   parameter int T_SMP = 1,
   parameter int T_HLD = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           cmp_hi,
   output logic [2*N-1:0] cap_sel,
   output logic           sw_dis,
   output logic           sw_smp,
   output logic           sw_hld,
   output logic           busy,
   output logic           done,
   output logic [N-1:0]   result
);
   if (N < 2) begin : g_bad_n
      $error("sar_ctrl: N must be at least 2");
   end
   if (T_DIS < 1 || T_SMP < 1 || T_HLD < 1) begin : g_bad_t
      $error("sar_ctrl: every phase length must be at least 1");
   end

   phase_e       ph;
   logic         ph_last;
   logic [N-1:0] trial_bits;

   sar_phase_seq #(.N(N), .T_DIS(T_DIS), .T_SMP(T_SMP), .T_HLD(T_HLD)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ph(ph), .ph_last(ph_last)
   );

   sar_bit_reg #(.N(N)) u_bits (
      .clk(clk), .rst_n(rst_n), .ph(ph), .ph_last(ph_last), .cmp_hi(cmp_hi),
      .trial_bits(trial_bits), .result(result), .done(done)
   );

   sar_switch_map #(.N(N)) u_map (
      .ph(ph), .trial_bits(trial_bits), .cap_sel(cap_sel)
   );

   assign sw_dis = (ph == PH_DIS);
   assign sw_smp = (ph == PH_SMP);
   assign sw_hld = (ph == PH_HLD) || (ph == PH_TRY);
   assign busy   = (ph != PH_IDLE);
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
   parameter int N = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic [2*N-1:0] cap_sel,
   input logic           sw_dis,
   input logic           sw_smp,
   input logic           sw_hld,
   input logic           busy,
   input logic           done,
   input logic [N-1:0]   result
);
   AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cap_sel == '0 && !sw_dis && !sw_smp && !sw_hld)); // R1
   AST_START_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> sw_dis); // R2
   AST_SAMPLE_AFTER_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_smp) |-> $past(sw_dis)); // R3
   AST_HOLD_AFTER_SMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_hld) |-> $past(sw_smp)); // R4
   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sw_dis, sw_smp, sw_hld})); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(rst_n)) |-> done); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && $past(rst_n)) |-> $stable(result)); // R7
endmodule

bind sar_ctrl sar_ctrl_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_sel(cap_sel), .sw_dis(sw_dis),
   .sw_smp(sw_smp), .sw_hld(sw_hld), .busy(busy), .done(done), .result(result)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
   localparam int N     = 8;
   localparam int TD    = 2;
   localparam int TS    = 3;
   localparam int TH    = 1;
   localparam int TPREP = TD + TS + TH;
   localparam int CLK_P = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           cmp_hi;
   logic [2*N-1:0] cap_sel;
   logic           sw_dis, sw_smp, sw_hld, busy, done;
   logic [N-1:0]   result;

   int  vin = 0;
   bit  force_en = 1'b0;
   bit  force_val = 1'b0;
   int  checks = 0;
   int  errors = 0;

   always #(CLK_P/2) clk = ~clk;

   function automatic int dac_of(logic [2*N-1:0] s);
      int acc = 0;
      for (int i = 0; i < N; i++) if (s[2*i +: 2] == 2'b11) acc += (1 << i);
      return acc;
   endfunction

   assign cmp_hi = force_en ? force_val : (vin >= dac_of(cap_sel));

   sar_ctrl #(.N(N), .T_DIS(TD), .T_SMP(TS), .T_HLD(TH)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
      .cap_sel(cap_sel), .sw_dis(sw_dis), .sw_smp(sw_smp), .sw_hld(sw_hld),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2*N-1:0] fill_sel(logic [1:0] code);
      logic [2*N-1:0] s;
      for (int i = 0; i < N; i++) s[2*i +: 2] = code;
      return s;
   endfunction

   function automatic logic [2*N-1:0] trial_sel(int bits);
      logic [2*N-1:0] s;
      for (int i = 0; i < N; i++) s[2*i +: 2] = bits[i] ? 2'b11 : 2'b01;
      return s;
   endfunction

   task automatic check_idle(string req, int exp_res);
      chk(cap_sel == '0, req, "idle cap_sel", cap_sel, 0);
      chk({sw_dis, sw_smp, sw_hld} == 3'b000, req, "idle phase switches",
          {sw_dis, sw_smp, sw_hld}, 0);
      chk(busy == 1'b0, req, "idle busy", busy, 0);
      chk(done == 1'b0, req, "idle done", done, 0);
      chk(result == exp_res[N-1:0], req, "idle result", result, exp_res);
   endtask

   task automatic run_conv(int v, bit fen, bit fval, bit poke);
      int eb = 0;
      vin = v; force_en = fen; force_val = fval;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int c = 0; c < TPREP + N; c++) begin
         start = 1'b0;
         chk(busy == 1'b1, "R7", "busy during conversion", busy, 1);
         if (c < TD) begin
            chk(cap_sel == fill_sel(2'b01), "R2", "discharge selects", cap_sel, fill_sel(2'b01));
            chk({sw_dis, sw_smp, sw_hld} == 3'b100, "R2", "discharge switches",
                {sw_dis, sw_smp, sw_hld}, 3'b100);
         end else if (c < TD + TS) begin
            chk(cap_sel == fill_sel(2'b10), "R3", "sample selects", cap_sel, fill_sel(2'b10));
            chk({sw_dis, sw_smp, sw_hld} == 3'b010, "R3", "sample switches",
                {sw_dis, sw_smp, sw_hld}, 3'b010);
         end else if (c < TPREP) begin
            chk(cap_sel == fill_sel(2'b01), "R4", "hold selects", cap_sel, fill_sel(2'b01));
            chk({sw_dis, sw_smp, sw_hld} == 3'b001, "R4", "hold switches",
                {sw_dis, sw_smp, sw_hld}, 3'b001);
         end else begin
            int k = N - 1 - (c - TPREP);
            int tb = eb | (1 << k);
            bit keep;
            chk(cap_sel == trial_sel(tb), "R5", "trial selects", cap_sel, trial_sel(tb));
            chk(sw_hld == 1'b1, "R4", "hold switch in trial", sw_hld, 1);
            keep = fen ? fval : (v >= tb);
            if (keep) eb = tb;
         end
         if (poke && c == TPREP + 1) start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R7", "done after LSB", done, 1);
      chk(busy == 1'b0, "R7", "busy low with done", busy, 0);
      chk(result == eb[N-1:0], "R6", "converted code", result, eb);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done one cycle", done, 0);
      chk(busy == 1'b0, poke ? "R8" : "R7", "no restart", busy, 0);
      chk(result == eb[N-1:0], "R7", "result held", result, eb);
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      check_idle("R1", 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1", 0);

      run_conv(0, 0, 0, 0);           // R6 zero
      run_conv(255, 0, 0, 0);         // R6 full scale
      run_conv(128, 0, 0, 0);         // R5 mid-scale
      run_conv(127, 0, 0, 0);         // R5 just below mid-scale
      run_conv(85, 0, 0, 0);          // R6 alternating
      run_conv(170, 0, 0, 0);         // R6 alternating
      run_conv(0, 1, 1, 0);           // R6 comparator stuck high
      run_conv(255, 1, 0, 0);         // R6 comparator stuck low
      run_conv(77, 0, 0, 1);          // R8 start while busy

      for (int n = 0; n < 40; n++) run_conv(int'($urandom % 256), 0, 0, n % 7 == 3);

      // R9 reset mid-conversion
      vin = 200; force_en = 1'b0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (TPREP + 2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R9", 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R9", 0);
      @(negedge clk);
      chk(busy == 1'b0, "R9", "stays idle", busy, 0);

      run_conv(201, 0, 0, 0);         // R2 fresh conversion after reset

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule